// File: doc/BRIEF.md
# Termination Enable Controller

This block holds the termination control logic of a DRAM device. It watches the mode-register-set strobe. When the strobe selects the extended register, the block stores the two-bit termination code carried on two address lines. It then combines that code with the device power state and the external termination pin. From these it produces a registered enable and a resistance selection for the termination network on the data and strobe lines.

Termination stays off after reset until a valid nonzero code has been written. It is forced off in self-refresh and in any power-state encoding that is not defined. A write of the reserved code leaves termination disabled and sets a flag that stays set until reset. All pins are plain control and status signals, so there is no back-pressure at this block's edge.

Top module: `term_enable_ctrl`

## Requirements
- R1: After reset, term_en is 0, term_sel is 2'b00 and rsvd_flag is 0.
- R2: A mode-register-set strobe (mrs_valid=1) with bank_addr=2'b01 stores the code {addr[6], addr[2]}. The code values are 2'b00 for disabled, 2'b01 for 75 ohm and 2'b10 for 150 ohm. The stored code takes effect on the enable computed at the next clock edge.
- R3: A mode-register-set strobe with bank_addr other than 2'b01 leaves the stored code unchanged.
- R4: When the power state permits termination and a nonzero code is stored, term_en takes the value odt_pin had one clock edge earlier, and term_sel then equals the stored code.
- R5: The power states that permit termination are 3'b000 (active/idle), 3'b001 (active power-down, fast exit), 3'b010 (active power-down, slow exit) and 3'b011 (precharge power-down).
- R6: In self-refresh (3'b100), and in the undefined encodings 3'b101 to 3'b111, odt_pin is ignored and term_en is 0 at the following edge.
- R7: From reset until a nonzero code has been stored, term_en remains 0 whatever odt_pin does.
- R8: A write of the reserved code 2'b11 stores the disabled code and sets rsvd_flag. rsvd_flag then stays 1 until reset, including across later valid writes.
- R9: term_sel is 2'b00 whenever term_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mrs_valid | input | 1 | Mode-register-set command strobe |
| bank_addr | input | 2 | Register select bits of the command |
| addr | input | ADDR_W | Address bus of the command |
| pwr_state | input | 3 | Device power state encoding |
| odt_pin | input | 1 | External termination control pin |
| term_en | output | 1 | Registered termination enable |
| term_sel | output | 2 | Selected resistance (00 off, 01 75 ohm, 10 150 ohm) |
| rsvd_flag | output | 1 | Sticky flag for a reserved code write |

## Verification
The main function is tried with the pin held high across a walk through every power-state encoding. This separates the four permitted states from self-refresh and from the undefined codes. It is also tried with the pin toggled before any write, after a 75 ohm write and after a 150 ohm write, which separates the reset gating from the code-driven selection. Commands addressed to the other three registers, carrying a nonzero field, show whether they reach the stored code. A reserved write followed by a valid write shows the flag's stickiness. A long constrained-random run then mixes strobes, bank values, codes, states and pin levels at once.

// File: rtl/term_pkg.sv
package term_pkg;
  typedef enum logic [2:0] {
    PS_ACTIVE   = 3'b000,
    PS_APD_FAST = 3'b001,
    PS_APD_SLOW = 3'b010,
    PS_PPD      = 3'b011,
    PS_SREF     = 3'b100
  } pwr_state_e;

  typedef enum logic [1:0] {
    RTT_OFF  = 2'b00,
    RTT_75   = 2'b01,
    RTT_150  = 2'b10,
    RTT_RSVD = 2'b11
  } rtt_code_e;
endpackage

// File: rtl/term_mrs_capture.sv
module term_mrs_capture #(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int EXT_BANK   = 1,
  parameter int SEL_HI_BIT = 6,
  parameter int SEL_LO_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_valid,
  input  logic [BA_W-1:0]   bank_addr,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        code_o,
  output logic              rsvd_o
);
  import term_pkg::*;

  localparam logic [BA_W-1:0] EXT_SEL = BA_W'(EXT_BANK);

  logic       hit;
  logic [1:0] field;
  logic       unused_addr_bits;

  assign unused_addr_bits = ^addr;
  assign hit   = mrs_valid && (bank_addr == EXT_SEL);
  assign field = {addr[SEL_HI_BIT], addr[SEL_LO_BIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= RTT_OFF;
      rsvd_o <= 1'b0;
    end else if (hit) begin
      if (field == RTT_RSVD) begin
        code_o <= RTT_OFF;
        rsvd_o <= 1'b1;
      end else begin
        code_o <= field;
      end
    end
  end
endmodule

// File: rtl/term_state_gate.sv
module term_state_gate #(
  parameter int              PS_W       = 3,
  parameter logic [7:0]      ALLOW_MASK = 8'b0000_1111
) (
  input  logic [PS_W-1:0] pwr_state,
  output logic            allowed_o
);
  localparam int N_STATES = 1 << PS_W;

  logic [N_STATES-1:0] permit;

  for (genvar s = 0; s < N_STATES; s++) begin : g_permit
    if (s < 8) begin : g_in
      assign permit[s] = ALLOW_MASK[s];
    end else begin : g_out
      assign permit[s] = 1'b0;
    end
  end

  assign allowed_o = permit[pwr_state];
endmodule

// File: rtl/term_out_reg.sv
module term_out_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odt_pin,
  input  logic       allowed,
  input  logic [1:0] code,
  output logic       term_en,
  output logic [1:0] term_sel
);
  import term_pkg::*;

  logic on_next;

  assign on_next = odt_pin && allowed && (code != RTT_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_en  <= 1'b0;
      term_sel <= RTT_OFF;
    end else begin
      term_en  <= on_next;
      term_sel <= on_next ? code : RTT_OFF;
    end
  end
endmodule

// File: rtl/term_enable_ctrl.sv
module term_enable_ctrl #(
  parameter int ADDR_W     = 13,
  parameter int EXT_BANK   = 1,
  parameter int SEL_HI_BIT = 6,
  parameter int SEL_LO_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_valid,
  input  logic [1:0]        bank_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        pwr_state,
  input  logic              odt_pin,
  output logic              term_en,
  output logic [1:0]        term_sel,
  output logic              rsvd_flag
);
  logic [1:0] code_q;
  logic       allowed;

  term_mrs_capture #(
    .ADDR_W(ADDR_W), .BA_W(2), .EXT_BANK(EXT_BANK),
    .SEL_HI_BIT(SEL_HI_BIT), .SEL_LO_BIT(SEL_LO_BIT)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid),
    .bank_addr(bank_addr), .addr(addr),
    .code_o(code_q), .rsvd_o(rsvd_flag)
  );

  term_state_gate #(.PS_W(3), .ALLOW_MASK(8'b0000_1111)) u_gate (
    .pwr_state(pwr_state), .allowed_o(allowed)
  );

  term_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .odt_pin(odt_pin), .allowed(allowed),
    .code(code_q), .term_en(term_en), .term_sel(term_sel)
  );
endmodule

// File: rtl/term_enable_ctrl_chk.sv
module term_enable_ctrl_chk #(
  parameter int ADDR_W     = 13,
  parameter int SEL_HI_BIT = 6,
  parameter int SEL_LO_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mrs_valid,
  input logic [1:0]        bank_addr,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        pwr_state,
  input logic              odt_pin,
  input logic              term_en,
  input logic [1:0]        term_sel,
  input logic              rsvd_flag,
  input logic [1:0]        code_q
);
  // R6
  sref_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state[2]) |=> !term_en);

  // R4
  pin_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!odt_pin) |=> !term_en);

  // R4
  pin_high_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_pin && !pwr_state[2] && code_q != 2'b00) |=> (term_en && term_sel == $past(code_q)));

  // R9
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_en) |-> (term_sel == 2'b00));

  // R2
  sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_en |-> (term_sel == 2'b01 || term_sel == 2'b10));

  // R8
  rsvd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_flag |=> rsvd_flag);

  // R8
  rsvd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_valid && bank_addr == 2'b01 && addr[SEL_HI_BIT] && addr[SEL_LO_BIT])
      |=> (rsvd_flag && code_q == 2'b00));

  // R3
  other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_valid && bank_addr != 2'b01) |=> $stable(code_q));
endmodule

bind term_enable_ctrl term_enable_ctrl_chk #(
  .ADDR_W(ADDR_W), .SEL_HI_BIT(SEL_HI_BIT), .SEL_LO_BIT(SEL_LO_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .bank_addr(bank_addr),
  .addr(addr), .pwr_state(pwr_state), .odt_pin(odt_pin), .term_en(term_en),
  .term_sel(term_sel), .rsvd_flag(rsvd_flag), .code_q(code_q)
);

// File: tb/term_enable_ctrl_tb.sv
module term_enable_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mrs_valid = 1'b0;
  logic [1:0]        bank_addr = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0]        pwr_state = 3'b000;
  logic              odt_pin = 1'b0;
  logic              term_en;
  logic [1:0]        term_sel;
  logic              rsvd_flag;

  int checks = 0;
  int fails  = 0;
  logic [1:0] code_m = 2'b00;
  logic       rsvd_m = 1'b0;
  logic       done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_enable_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .bank_addr(bank_addr),
    .addr(addr), .pwr_state(pwr_state), .odt_pin(odt_pin),
    .term_en(term_en), .term_sel(term_sel), .rsvd_flag(rsvd_flag)
  );

  function automatic logic permitted(input logic [2:0] ps);
    return ps <= 3'b011;
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [1:0] c, input logic [ADDR_W-1:0] junk);
    logic [ADDR_W-1:0] a;
    a = junk;
    a[6] = c[1];
    a[2] = c[0];
    return a;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive, predict, wait one edge, compare at next negedge.
  task automatic step(input string tag, input logic mv, input logic [1:0] ba,
                      input logic [ADDR_W-1:0] ad, input logic [2:0] ps, input logic pin);
    logic       e_en;
    logic [1:0] e_sel;
    mrs_valid = mv; bank_addr = ba; addr = ad; pwr_state = ps; odt_pin = pin;
    e_en  = pin && permitted(ps) && (code_m != 2'b00);
    e_sel = e_en ? code_m : 2'b00;
    if (mv && ba == 2'b01) begin
      if ({ad[6], ad[2]} == 2'b11) begin
        code_m = 2'b00;
        rsvd_m = 1'b1;
      end else begin
        code_m = {ad[6], ad[2]};
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(term_en), int'(e_en));
    check(tag, int'(term_sel), int'(e_sel));
    check("R8", int'(rsvd_flag), int'(rsvd_m));
  endtask

  task automatic emr(input string tag, input logic [1:0] c, input logic [2:0] ps);
    step(tag, 1'b1, 2'b01, mk_addr(c, '0), ps, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(term_en), 0);
    check("R1", int'(term_sel), 0);
    check("R1", int'(rsvd_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: pin high before any write
    for (int i = 0; i < 4; i++) step("R7", 1'b0, 2'b00, '0, 3'b000, 1'b1);
    // R3: other registers with nonzero field
    for (int b = 0; b < 4; b++)
      if (b != 1) step("R3", 1'b1, 2'(b), mk_addr(2'b01, '0), 3'b000, 1'b1);
    step("R7", 1'b0, 2'b00, '0, 3'b000, 1'b1);

    // R2: 75 ohm, then R4 latency
    emr("R2", 2'b01, 3'b000);
    step("R4", 1'b0, 2'b00, '0, 3'b000, 1'b1);
    step("R4", 1'b0, 2'b00, '0, 3'b000, 1'b0);
    step("R4", 1'b0, 2'b00, '0, 3'b000, 1'b1);
    // R5 / R6: walk all state encodings with pin high
    for (int s = 0; s < 8; s++)
      step(s < 4 ? "R5" : "R6", 1'b0, 2'b00, '0, 3'(s), 1'b1);
    // R2: 150 ohm
    emr("R2", 2'b10, 3'b011);
    step("R2", 1'b0, 2'b00, '0, 3'b011, 1'b1);
    step("R9", 1'b0, 2'b00, '0, 3'b100, 1'b1);
    // R3: other bank leaves 150 in place
    step("R3", 1'b1, 2'b10, mk_addr(2'b01, '0), 3'b000, 1'b1);
    step("R3", 1'b0, 2'b00, '0, 3'b000, 1'b1);
    // R8: reserved write then valid write
    emr("R8", 2'b11, 3'b000);
    step("R8", 1'b0, 2'b00, '0, 3'b000, 1'b1);
    emr("R8", 2'b01, 3'b000);
    step("R8", 1'b0, 2'b00, '0, 3'b001, 1'b1);

    // reset again: flag cleared, code cleared
    rst_n = 1'b0;
    code_m = 2'b00; rsvd_m = 1'b0;
    @(negedge clk);
    check("R1", int'(rsvd_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R7", 1'b0, 2'b00, '0, 3'b000, 1'b1);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic       mv;
      logic [1:0] ba;
      logic [2:0] ps;
      logic       pin;
      logic [ADDR_W-1:0] ad;
      string tag;
      mv  = ($urandom % 6) == 0;
      ba  = 2'($urandom);
      ps  = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 4);
      pin = ($urandom % 4) != 0;
      ad  = ADDR_W'($urandom);
      if (!permitted(ps))        tag = "R6";
      else if (code_m == 2'b00)  tag = "R7";
      else                       tag = "R4";
      step(tag, mv, ba, ad, ps, pin);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule